// File: doc/BRIEF.md
# Run-Time Selectable Triggered Signal Sampler

This block watches a wide bank of 32-bit probe inputs. It routes any four of them to four capture channels, and the choice is made at run time. Each channel has its own select index, and that index may change while a capture is running. Each channel is built as an AND-OR network: every probe is masked with a one-hot decode of the index, and the masked words are ORed together. The network therefore needs no dedicated wide-multiplexer resources.

A base tick strobe (nominally 1 MHz) is divided down to one of 25 sample rates. A start pulse loads the run settings: rate, sample total, endless mode and trigger compare. It also clears the sample number. A capture then runs in one of two ways. In counted mode it takes a fixed number of samples, a multiple of 1024. In endless mode it runs until a stop pulse. An optional compare trigger on channel 0 holds sampling off until the compare condition is met. Every sample presents the four channel values, a 32-bit running sample number and a one-cycle valid strobe.

Top module: `signal_sampler`

## Requirements
- R1: Channel c samples the probe whose index is given by field c of the select bus (bits c*SEL_W upward). An index at or above NUM_PROBES yields zero. A new index takes effect at the next sample, without a restart.
- R2: After reset, valid is low and the sample number and all channel outputs are zero. No sample appears until a start pulse arrives.
- R3: Samples are taken only on tick cycles, once every N ticks. N comes from the rate code: 0..24 map to 1,2,4,5,8,10,16,20,25,32,40,50,64,80,100,125,160,200,250,320,400,500,640,800,1000. Codes 25..31 act as code 24.
- R4: In counted mode (endless low) the run ends by itself after exactly B*1024 samples. B is the block setting, with 0 treated as 1 and values above 976 treated as 976.
- R5: In endless mode sampling goes on until a stop pulse. No valid follows a stop pulse until the next start.
- R6: With the trigger disabled, the first tick after the start pulse produces sample 0.
- R7: With the trigger enabled, sampling waits until the unsigned compare on channel 0 holds on a tick. The condition codes are 0 = greater than the threshold, 1 = less than, 2 = equal, 3 = never. The first sample is taken on that tick.
- R8: Once the trigger has fired, sampling continues for the rest of the run even if the condition becomes false.
- R9: The sample number is 0 for the first sample after a start pulse and rises by one with each later sample.
- R10: Valid is high for one cycle, in the cycle after the tick that took the sample. The channel values and the sample number hold until the next sample.
- R11: A start pulse during a run restarts it with fresh settings and the number back at 0. A stop pulse in the same cycle as a start pulse wins, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base sampling tick strobe |
| probes_i | input | NUM_PROBES*32 | Flattened probe bank, probe k at bits k*32 upward |
| sel_i | input | NUM_CH*SEL_W | Per-channel probe index |
| rate_i | input | 5 | Rate code |
| blocks_i | input | 10 | Sample total in units of 1024 (counted mode) |
| endless_i | input | 1 | 1 = run until stopped |
| trig_en_i | input | 1 | 1 = wait for the compare trigger |
| trig_cond_i | input | 2 | Compare condition code |
| trig_val_i | input | 32 | Compare threshold |
| start_i | input | 1 | Start pulse; loads the settings |
| stop_i | input | 1 | Stop pulse |
| smp_data_o | output | NUM_CH*32 | Sampled channel values, channel c at bits c*32 upward |
| smp_num_o | output | 32 | Sample number of the current sample |
| smp_valid_o | output | 1 | One-cycle sample strobe |

## Verification
Several properties are checked on every cycle:
- a valid strobe always follows a tick;
- an idle block and a stop pulse both silence the next cycle;
- the divider count stays below its ratio;
- a counted run never holds a sample number at or past its total.

Other behaviour is visible only in the bench's scenarios. These cover the exact spacing of samples for a rate code and the exact count at which a counted run ends. They also cover the compare trigger firing on the right tick and then staying latched, the zero result for an out-of-range index, and restart or stop priority. The bench runs a lockstep model against directed and random runs to show these.

// File: rtl/sampler_pkg.sv
package sampler_pkg;

  localparam int PROBE_W    = 32;
  localparam int RATE_W     = 5;
  localparam int BLOCK_W    = 10;
  localparam int RATIO_W    = 10;
  localparam int BLOCK_SH   = 10;
  localparam int LIMIT_W    = BLOCK_W + BLOCK_SH;
  localparam int NUM_W      = 32;
  localparam int MAX_BLOCKS = 976;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} run_state_e;
  typedef enum logic [1:0] {CMP_GT, CMP_LT, CMP_EQ, CMP_NEVER} cmp_e;

  // divider ratio for each rate code; codes past the table give the slowest rate
  function automatic logic [RATIO_W-1:0] rate_ratio(input logic [RATE_W-1:0] code);
    case (code)
      5'd0:  return 10'd1;
      5'd1:  return 10'd2;
      5'd2:  return 10'd4;
      5'd3:  return 10'd5;
      5'd4:  return 10'd8;
      5'd5:  return 10'd10;
      5'd6:  return 10'd16;
      5'd7:  return 10'd20;
      5'd8:  return 10'd25;
      5'd9:  return 10'd32;
      5'd10: return 10'd40;
      5'd11: return 10'd50;
      5'd12: return 10'd64;
      5'd13: return 10'd80;
      5'd14: return 10'd100;
      5'd15: return 10'd125;
      5'd16: return 10'd160;
      5'd17: return 10'd200;
      5'd18: return 10'd250;
      5'd19: return 10'd320;
      5'd20: return 10'd400;
      5'd21: return 10'd500;
      5'd22: return 10'd640;
      5'd23: return 10'd800;
      default: return 10'd1000;
    endcase
  endfunction

  // sample total of a counted run: clamped block count times 1024
  function automatic logic [LIMIT_W-1:0] count_limit(input logic [BLOCK_W-1:0] blocks);
    logic [BLOCK_W-1:0] b;
    if (blocks == '0)                    b = BLOCK_W'(1);
    else if (blocks > BLOCK_W'(MAX_BLOCKS)) b = BLOCK_W'(MAX_BLOCKS);
    else                                 b = blocks;
    return {b, {BLOCK_SH{1'b0}}};
  endfunction

  // unsigned compare condition
  function automatic logic cmp_hit(input logic [PROBE_W-1:0] v,
                                   input logic [PROBE_W-1:0] t,
                                   input logic [1:0] c);
    case (cmp_e'(c))
      CMP_GT:  return v > t;
      CMP_LT:  return v < t;
      CMP_EQ:  return v == t;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/probe_select.sv
module probe_select #(
  parameter int NUM_PROBES = 48,
  parameter int SEL_W      = 6,
  parameter int W          = 32
) (
  input  logic [NUM_PROBES*W-1:0] probes_i,
  input  logic [SEL_W-1:0]        index_i,
  output logic [W-1:0]            value_o
);

  // one-hot decode of the index, one bit per probe
  logic [NUM_PROBES-1:0] hot;

  for (genvar k = 0; k < NUM_PROBES; k++) begin : g_dec
    assign hot[k] = (index_i == SEL_W'(k));
  end

  // masked AND followed by a bitwise OR across all probes
  always_comb begin
    value_o = '0;
    for (int k = 0; k < NUM_PROBES; k++) begin
      value_o = value_o | (probes_i[k*W +: W] & {W{hot[k]}});
    end
  end

endmodule

// File: rtl/sample_trigger.sv
module sample_trigger
  import sampler_pkg::*;
(
  input  logic [PROBE_W-1:0] value_i,
  input  logic [PROBE_W-1:0] thresh_i,
  input  logic [1:0]         cond_i,
  output logic               hit_o
);

  assign hit_o = cmp_hit(value_i, thresh_i, cond_i);

endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             fire_o
);

  logic [CNT_W-1:0] cnt_q;

  // the count of zero means the next enabled tick samples
  assign fire_o = tick_i && en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (reload_i) begin
      cnt_q <= '0;
    end else if (tick_i && en_i) begin
      cnt_q <= (cnt_q == '0) ? ratio_i - CNT_W'(1) : cnt_q - CNT_W'(1);
    end
  end

  assert_div_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_i)
    else $error("divider count left its range");

endmodule

// File: rtl/signal_sampler.sv
module signal_sampler
  import sampler_pkg::*;
#(
  parameter int NUM_PROBES = 48,
  parameter int NUM_CH     = 4,
  parameter int SEL_W      = $clog2(NUM_PROBES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tick_i,
  input  logic [NUM_PROBES*PROBE_W-1:0] probes_i,
  input  logic [NUM_CH*SEL_W-1:0]     sel_i,
  input  logic [RATE_W-1:0]           rate_i,
  input  logic [BLOCK_W-1:0]          blocks_i,
  input  logic                        endless_i,
  input  logic                        trig_en_i,
  input  logic [1:0]                  trig_cond_i,
  input  logic [PROBE_W-1:0]          trig_val_i,
  input  logic                        start_i,
  input  logic                        stop_i,
  output logic [NUM_CH*PROBE_W-1:0]   smp_data_o,
  output logic [NUM_W-1:0]            smp_num_o,
  output logic                        smp_valid_o
);

  localparam int W = PROBE_W;

  run_state_e           st_q;
  logic [RATIO_W-1:0]   ratio_q;
  logic [LIMIT_W-1:0]   lim_q;
  logic                 endless_q;
  logic [1:0]           cond_q;
  logic [W-1:0]         tval_q;
  logic [NUM_W-1:0]     num_q;
  logic [NUM_CH*W-1:0]  chan_val;

  // named internal events
  logic trig_hit;
  logic div_en;
  logic div_fire;
  logic take;
  logic last_take;
  logic reload;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    probe_select #(
      .NUM_PROBES(NUM_PROBES),
      .SEL_W     (SEL_W),
      .W         (W)
    ) u_sel (
      .probes_i(probes_i),
      .index_i (sel_i[c*SEL_W +: SEL_W]),
      .value_o (chan_val[c*W +: W])
    );
  end

  sample_trigger u_trig (
    .value_i (chan_val[W-1:0]),
    .thresh_i(tval_q),
    .cond_i  (cond_q),
    .hit_o   (trig_hit)
  );

  assign div_en = (st_q == ST_RUN) || ((st_q == ST_ARMED) && trig_hit);

  rate_divider #(.CNT_W(RATIO_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(reload),
    .tick_i  (tick_i),
    .en_i    (div_en),
    .ratio_i (ratio_q),
    .fire_o  (div_fire)
  );

  assign take      = div_fire && !start_i && !stop_i;
  assign last_take = take && !endless_q && ((num_q + NUM_W'(1)) == NUM_W'(lim_q));
  assign reload    = start_i || stop_i || last_take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ratio_q     <= RATIO_W'(1);
      lim_q       <= '0;
      endless_q   <= 1'b0;
      cond_q      <= '0;
      tval_q      <= '0;
      num_q       <= '0;
      smp_data_o  <= '0;
      smp_num_o   <= '0;
      smp_valid_o <= 1'b0;
    end else begin
      smp_valid_o <= take;
      if (stop_i) begin
        st_q <= ST_IDLE;
      end else if (start_i) begin
        st_q      <= trig_en_i ? ST_ARMED : ST_RUN;
        ratio_q   <= rate_ratio(rate_i);
        lim_q     <= count_limit(blocks_i);
        endless_q <= endless_i;
        cond_q    <= trig_cond_i;
        tval_q    <= trig_val_i;
        num_q     <= '0;
      end else if (take) begin
        smp_data_o <= chan_val;
        smp_num_o  <= num_q;
        num_q      <= num_q + NUM_W'(1);
        st_q       <= last_take ? ST_IDLE : ST_RUN;
      end
    end
  end

  assert_valid_follows_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(tick_i))
    else $error("valid without a preceding tick");

  assert_idle_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |=> !smp_valid_o)
    else $error("sample taken while idle");

  assert_stop_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !smp_valid_o)
    else $error("sample after stop");

  assert_count_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q != ST_IDLE) && !endless_q) |-> (num_q < NUM_W'(lim_q)))
    else $error("counted run passed its total");

endmodule

// File: tb/signal_sampler_tb.sv
module signal_sampler_tb;

  localparam int NP = 48;
  localparam int NC = 4;
  localparam int W  = 32;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              tick, start, stop, endless, trig_en;
  logic [4:0]        rate;
  logic [9:0]        blocks;
  logic [1:0]        cond;
  logic [31:0]       tval;
  logic [NP*W-1:0]   probes;
  logic [NC*SW-1:0]  sel;
  logic [NC*W-1:0]   data_o;
  logic [31:0]       num_o;
  logic              valid_o;

  signal_sampler u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .probes_i(probes), .sel_i(sel),
    .rate_i(rate), .blocks_i(blocks), .endless_i(endless), .trig_en_i(trig_en),
    .trig_cond_i(cond), .trig_val_i(tval), .start_i(start), .stop_i(stop),
    .smp_data_o(data_o), .smp_num_o(num_o), .smp_valid_o(valid_o)
  );

  int checks = 0;
  int errors = 0;
  int nvalid = 0;
  string tag = "R2";

  // reference model state
  int          m_state = 0;   // 0 idle, 1 waiting for trigger, 2 sampling
  int          m_wait = 0, m_ratio = 1, m_lim = 0, m_num = 0;
  bit          m_inf = 0;
  logic [1:0]  m_cond = 0;
  logic [31:0] m_tval = 0;
  bit          exp_valid = 0;
  logic [31:0] exp_num = 0;
  logic [31:0] exp_data [NC];

  bit          ramp_on = 0;
  int          ramp_idx = 0;
  logic [31:0] ramp_val = 0;

  int RT [25] = '{1,2,4,5,8,10,16,20,25,32,40,50,64,80,100,125,160,200,250,320,400,500,640,800,1000};

  function automatic int ratio_of(int code);
    return (code > 24) ? RT[24] : RT[code];
  endfunction

  function automatic int lim_of(int k);
    int b;
    b = (k == 0) ? 1 : k;
    if (b > 976) b = 976;
    return b * 1024;
  endfunction

  function automatic logic [31:0] pick(int ch);
    int s;
    s = int'(sel[ch*SW +: SW]);
    if (s >= NP) return 32'd0;
    return probes[s*W +: W];
  endfunction

  function automatic bit cond_met(logic [31:0] v, logic [31:0] t, logic [1:0] c);
    if (c == 2'd0) return v > t;
    if (c == 2'd1) return v < t;
    if (c == 2'd2) return v == t;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    exp_valid = 0;
    if (stop) begin
      m_state = 0; m_wait = 0;
    end else if (start) begin
      m_ratio = ratio_of(int'(rate));
      m_lim   = lim_of(int'(blocks));
      m_inf   = endless;
      m_cond  = cond;
      m_tval  = tval;
      m_state = trig_en ? 1 : 2;
      m_num   = 0;
      m_wait  = 0;
    end else if (tick && m_state != 0) begin
      if (m_state == 2 || cond_met(pick(0), m_tval, m_cond)) begin
        if (m_wait == 0) begin
          exp_valid = 1;
          for (int ch = 0; ch < NC; ch++) exp_data[ch] = pick(ch);
          exp_num = m_num;
          m_num++;
          m_wait = m_ratio - 1;
          m_state = 2;
          if (!m_inf && m_num == m_lim) begin
            m_state = 0; m_wait = 0;
          end
        end else begin
          m_wait--;
        end
      end
    end
  endtask

  task automatic compare();
    check(valid_o == exp_valid, tag, "valid", 32'(valid_o), 32'(exp_valid));
    check(num_o == exp_num, tag, "sample number", num_o, exp_num);
    for (int ch = 0; ch < NC; ch++)
      check(data_o[ch*W +: W] == exp_data[ch], tag, $sformatf("channel %0d", ch),
            data_o[ch*W +: W], exp_data[ch]);
    if (valid_o) nvalid++;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    start = 0;
    stop  = 0;
  endtask

  task automatic fill_probes();
    for (int i = 0; i < NP; i++) probes[i*W +: W] = $urandom;
    if (ramp_on) begin
      probes[ramp_idx*W +: W] = ramp_val;
      ramp_val = ramp_val + 1;
    end
  endtask

  // mode 0: tick every cycle, 1: every other cycle, 2: random
  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      if (mode == 0)      tick = 1;
      else if (mode == 1) tick = (i % 2 == 0);
      else                tick = ($urandom % 3 == 0);
      fill_probes();
      cycle();
    end
  endtask

  task automatic rand_sel(bit allow_oob);
    for (int ch = 0; ch < NC; ch++)
      sel[ch*SW +: SW] = allow_oob ? SW'($urandom % 64) : SW'($urandom % NP);
  endtask

  initial begin
    int seed_dummy;
    int n0;
    seed_dummy = $urandom(32'h5EED1234);
    for (int ch = 0; ch < NC; ch++) exp_data[ch] = '0;
    tick = 0; start = 0; stop = 0; endless = 0; trig_en = 0;
    rate = 0; blocks = 0; cond = 0; tval = 0; probes = '0; sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2: reset state
    tag = "R2";
    compare();
    run(20, 0);
    check(nvalid == 0, "R2", "samples before start", 32'(nvalid), 0);

    // R1 / R6 / R4: counted run, block 0 -> 1024 samples, one index out of range
    tag = "R1";
    rand_sel(0);
    sel[3*SW +: SW] = 6'd60;
    rate = 0; blocks = 0; endless = 0; trig_en = 0;
    nvalid = 0;
    start = 1; tick = 1; fill_probes(); cycle();
    tag = "R6";
    run(1, 0);
    check(nvalid == 1 && num_o == 0, "R6", "first sample at first tick", 32'(nvalid), 1);
    tag = "R1";
    run(500, 0);
    rand_sel(1);
    run(600, 0);
    check(nvalid == 1024, "R4", "counted run total", 32'(nvalid), 1024);

    // R3: ratio 5, tick every other cycle
    tag = "R3";
    rate = 3; blocks = 1; nvalid = 0;
    start = 1; tick = 0; cycle();
    run(1024 * 5 * 2 + 40, 1);
    check(nvalid == 1024, "R3", "samples at ratio 5", 32'(nvalid), 1024);

    // R5 / R3: clamped code -> ratio 1000, endless, then stop
    tag = "R5";
    rate = 5'd30; endless = 1; nvalid = 0;
    start = 1; tick = 0; cycle();
    run(3100, 0);
    check(nvalid == 4, "R3", "samples at slowest rate", 32'(nvalid), 4);
    rate = 0;
    start = 1; tick = 0; cycle();
    run(30, 0);
    stop = 1; tick = 1; fill_probes(); cycle();
    n0 = nvalid;
    run(200, 0);
    check(nvalid == n0, "R5", "no samples after stop", 32'(nvalid), 32'(n0));

    // R7 / R8: greater-than trigger on a ramp
    tag = "R7";
    ramp_on = 1; ramp_idx = 5; ramp_val = 0;
    sel[0 +: SW] = 6'd5;
    rate = 2; endless = 1; trig_en = 1; cond = 2'd0; tval = 200; nvalid = 0;
    start = 1; tick = 0; cycle();
    run(200, 0);
    check(nvalid == 0, "R7", "held off below threshold", 32'(nvalid), 0);
    run(100, 0);
    check(nvalid == 25, "R7", "samples after trigger", 32'(nvalid), 25);
    tag = "R8";
    ramp_val = 0;
    n0 = nvalid;
    run(100, 0);
    check(nvalid - n0 == 25, "R8", "trigger stays latched", 32'(nvalid - n0), 25);
    stop = 1; tick = 0; cycle();

    tag = "R7";
    ramp_val = 0; cond = 2'd2; tval = 50; rate = 0;
    start = 1; cycle();
    run(120, 0);
    stop = 1; tick = 0; cycle();
    ramp_val = 1000; cond = 2'd1; tval = 30; nvalid = 0;
    start = 1; cycle();
    run(60, 0);
    check(nvalid == 0, "R7", "less-than not met", 32'(nvalid), 0);
    stop = 1; tick = 0; cycle();
    cond = 2'd3; tval = 0; nvalid = 0;
    start = 1; cycle();
    run(300, 0);
    check(nvalid == 0, "R7", "never condition", 32'(nvalid), 0);
    stop = 1; tick = 0; cycle();
    ramp_on = 0; trig_en = 0;

    // R11 / R9: restart mid run, stop beats start
    tag = "R11";
    rate = 1; endless = 1;
    start = 1; tick = 0; cycle();
    run(37, 0);
    start = 1; tick = 1; fill_probes(); cycle();
    tag = "R9";
    run(1, 0);
    check(valid_o && num_o == 0, "R9", "number back to zero", num_o, 0);
    run(10, 0);
    tag = "R11";
    start = 1; stop = 1; tick = 1; fill_probes(); cycle();
    n0 = nvalid;
    run(50, 0);
    check(nvalid == n0, "R11", "stop wins over start", 32'(nvalid), 32'(n0));

    // R10: random endless runs with random triggers and select changes
    tag = "R10";
    for (int it = 0; it < 25; it++) begin
      rand_sel(1);
      rate = 5'($urandom % 9);
      endless = 1;
      trig_en = $urandom % 2;
      cond = 2'($urandom % 3);
      tval = $urandom;
      start = 1; tick = 0; cycle();
      for (int k = 0; k < 4; k++) begin
        run(60 + ($urandom % 100), 2);
        if ($urandom % 2 == 0) rand_sel(1);
      end
      stop = 1; tick = 0; cycle();
      run(3, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule